// File: doc/BRIEF.md
# Nibble-Wide DRAM Display Fetch Sequencer

This block pulls display bytes out of a DRAM bank that is only four bits wide. Time is split into periods of eight clocks. A period in which a fetch is allowed uses the standard row/column protocol. The block puts the row half of the display address on a shared address bus and lowers the row strobe. It then makes two column accesses, one at the even column and one at the odd column derived from the low address bits. Each column access returns one nibble. The first nibble becomes the upper half of a byte and the second nibble the lower half.

Once the byte is complete, the block presents it with a one-cycle valid pulse for the pixel stage. It then moves the display address forward by eight, which is the next character column. When the new address reaches or passes the top of screen memory, the configured screen size is subtracted from it. An access divisor, chosen from the display mode, limits fetches to one period in every N. Fetches are also suppressed outside the active fetch window and on blank spacing lines between character rows.

Top module: `nfs_fetch_seq`

## Requirements
- R1: While `rst` is high, `ras_n` and `cas_n` are 1, `byte_valid` is 0, and `fetch_byte` and `mem_addr` are 0. The display address is loaded from `start_addr`.
- R2: After `rst` falls, the first rising edge is phase 0 of a period. Periods last 8 clocks. The fetch decision uses `fetch_win`, `row_gap` and the access counter as sampled at that period's phase 0 edge.
- R3: A period fetches only when the access counter is 0, `fetch_win` is 1 and `row_gap` is 0. In any other period, `ras_n` and `cas_n` stay 1 and `byte_valid` stays 0 for all 8 cycles, and `fetch_byte` keeps its value.
- R4: In a fetching period, `mem_addr` holds display address bits 15..7 in the cycle after the phase 0 edge. `ras_n` is 0 from the phase 1 edge until the phase 7 edge.
- R5: At the phase 1 edge, `mem_addr` becomes {address bits 6..0, 0}. `cas_n` is 0 after the phase 2 and phase 3 edges. `dram_q` sampled at the phase 3 edge forms `fetch_byte[7:4]`.
- R6: At the phase 4 edge, `cas_n` returns to 1 for one cycle and `mem_addr` becomes {address bits 6..0, 1}. `cas_n` is 0 again after the phase 5 edge. `dram_q` sampled at the phase 6 edge forms `fetch_byte[3:0]`.
- R7: The assembled byte appears on `fetch_byte` at the phase 6 edge, with `byte_valid` at 1 for exactly that one cycle (phase 7). After the phase 7 edge, both strobes are 1.
- R8: Each fetch adds 8 to the display address. If the sum is 0x8000 or more, `screen_size` is subtracted from it.
- R9: The access counter steps at every phase 7 edge, whether or not a fetch took place, and returns to 0 when its next value would reach `access_div`. An `access_div` of 0 or 1 allows a fetch in every period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| start_addr | input | 16 | Display address loaded during reset |
| fetch_win | input | 1 | High while the fetch window is open |
| row_gap | input | 1 | High on a blank spacing line between character rows |
| access_div | input | 4 | Periods per fetch slot (mode dependent) |
| screen_size | input | 16 | Bytes subtracted when the address wraps |
| dram_q | input | 4 | Nibble returned by the DRAM |
| mem_addr | output | 9 | Multiplexed row/column address |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| fetch_byte | output | 8 | Last assembled byte |
| byte_valid | output | 1 | One-cycle pulse when a new byte is ready |

## Verification
The bench builds the block with its default parameters: a 16-bit address, 4-bit nibbles, an 8-phase period and a 4-bit divisor. This lets it try every divisor from 0 to 4 together with two screen sizes. Start addresses just below 0x8000 bring the wrap subtraction into view within a few periods. The DRAM model returns nibbles from an arithmetic function of the latched row and the column. Each assembled byte, and every strobe and address phase, is therefore predicted without any stored memory.

// File: rtl/nfs_pkg.sv
package nfs_pkg;
  localparam int ADDR_W     = 16;
  localparam int NIB_W      = 4;
  localparam int DIV_W      = 4;
  localparam int PHASES     = 8;
  localparam int ROW_LSB    = 7;
  localparam int ADDR_STEP  = 8;
  localparam int SCREEN_TOP = 32'h8000;

  typedef enum logic [2:0] {
    PH_ROW   = 3'd0,
    PH_RAS   = 3'd1,
    PH_CAS0  = 3'd2,
    PH_HI    = 3'd3,
    PH_COL1  = 3'd4,
    PH_CAS1  = 3'd5,
    PH_LO    = 3'd6,
    PH_END   = 3'd7
  } phase_e;
endpackage

// File: rtl/nfs_phase_ctr.sv
module nfs_phase_ctr #(
  parameter int PHASES = 8,
  localparam int PH_W = $clog2(PHASES)
) (
  input  logic            clk,
  input  logic            rst,
  output logic [PH_W-1:0] phase,
  output logic            last
);
  assign last = (phase == PH_W'(PHASES - 1));

  always_ff @(posedge clk) begin
    if (rst)       phase <= '0;
    else if (last) phase <= '0;
    else           phase <= phase + 1'b1;
  end
endmodule

// File: rtl/nfs_access_div.sv
module nfs_access_div #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             advance,
  input  logic [DIV_W-1:0] divisor,
  output logic             zero
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W:0]   nxt;

  assign nxt  = {1'b0, cnt} + 1'b1;
  assign zero = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (advance)
      cnt <= (nxt >= {1'b0, divisor}) ? '0 : nxt[DIV_W-1:0];
  end
endmodule

// File: rtl/nfs_addr_gen.sv
module nfs_addr_gen #(
  parameter int ADDR_W = 16,
  parameter int STEP   = 8,
  parameter int TOP    = 32'h8000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [ADDR_W-1:0] screen_size,
  input  logic              step,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W:0] sum;
  logic [ADDR_W:0] wrapped;

  assign sum     = {1'b0, addr} + (ADDR_W+1)'(STEP);
  assign wrapped = (sum >= (ADDR_W+1)'(TOP)) ? (sum - {1'b0, screen_size}) : sum;

  always_ff @(posedge clk) begin
    if (rst)       addr <= start_addr;
    else if (step) addr <= wrapped[ADDR_W-1:0];
  end
endmodule

// File: rtl/nfs_fetch_seq.sv
module nfs_fetch_seq
  import nfs_pkg::*;
#(
  parameter int AW      = ADDR_W,
  parameter int NW      = NIB_W,
  parameter int DW      = DIV_W,
  parameter int RLSB    = ROW_LSB,
  parameter int STEP    = ADDR_STEP,
  parameter int TOP     = SCREEN_TOP,
  localparam int ROW_W  = AW - RLSB,
  localparam int COL_W  = RLSB + 1,
  localparam int MUX_W  = (ROW_W > COL_W) ? ROW_W : COL_W,
  localparam int BYTE_W = 2 * NW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     start_addr,
  input  logic              fetch_win,
  input  logic              row_gap,
  input  logic [DW-1:0]     access_div,
  input  logic [AW-1:0]     screen_size,
  input  logic [NW-1:0]     dram_q,
  output logic [MUX_W-1:0]  mem_addr,
  output logic              ras_n,
  output logic              cas_n,
  output logic [BYTE_W-1:0] fetch_byte,
  output logic              byte_valid
);
  logic [2:0]    phase;
  logic          last_phase;
  logic          acc_zero;
  logic          go;
  logic          active;
  logic          step;
  logic [AW-1:0] disp_addr;
  logic [NW-1:0] hi_nib;
  phase_e        ph;

  nfs_phase_ctr #(.PHASES(PHASES)) u_phase (
    .clk(clk), .rst(rst), .phase(phase), .last(last_phase)
  );

  nfs_access_div #(.DIV_W(DW)) u_div (
    .clk(clk), .rst(rst), .advance(last_phase),
    .divisor(access_div), .zero(acc_zero)
  );

  nfs_addr_gen #(.ADDR_W(AW), .STEP(STEP), .TOP(TOP)) u_addr (
    .clk(clk), .rst(rst), .start_addr(start_addr),
    .screen_size(screen_size), .step(step), .addr(disp_addr)
  );

  assign ph   = phase_e'(phase);
  assign go   = acc_zero & fetch_win & ~row_gap;
  assign step = active & (ph == PH_LO);

  function automatic logic [MUX_W-1:0] row_of(input logic [AW-1:0] a);
    return MUX_W'(a[AW-1:RLSB]);
  endfunction

  function automatic logic [MUX_W-1:0] col_of(input logic [AW-1:0] a, input logic odd);
    return MUX_W'({a[RLSB-1:0], odd});
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      active     <= 1'b0;
      mem_addr   <= '0;
      ras_n      <= 1'b1;
      cas_n      <= 1'b1;
      hi_nib     <= '0;
      fetch_byte <= '0;
      byte_valid <= 1'b0;
    end else begin
      byte_valid <= 1'b0;
      case (ph)
        PH_ROW: begin
          active <= go;
          if (go) mem_addr <= row_of(disp_addr);
        end
        PH_RAS: if (active) begin
          ras_n    <= 1'b0;
          mem_addr <= col_of(disp_addr, 1'b0);
        end
        PH_CAS0: if (active) cas_n <= 1'b0;
        PH_HI:   if (active) hi_nib <= dram_q;
        PH_COL1: if (active) begin
          cas_n    <= 1'b1;
          mem_addr <= col_of(disp_addr, 1'b1);
        end
        PH_CAS1: if (active) cas_n <= 1'b0;
        PH_LO: if (active) begin
          fetch_byte <= {hi_nib, dram_q};
          byte_valid <= 1'b1;
        end
        PH_END: begin
          ras_n  <= 1'b1;
          cas_n  <= 1'b1;
          active <= 1'b0;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/nfs_fetch_chk.sv
module nfs_fetch_chk #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [2:0]        phase,
  input logic              ras_n,
  input logic              cas_n,
  input logic              byte_valid,
  input logic [BYTE_W-1:0] fetch_byte
);
  p_ras_fall_phase_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_n) |-> (phase == 3'd2));

  p_ras_holds_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_n) |=> !ras_n);

  p_cas_under_ras_r5: assert property (@(posedge clk) disable iff (rst)
    !cas_n |-> !ras_n);

  p_valid_one_cycle_r7: assert property (@(posedge clk) disable iff (rst)
    byte_valid |=> !byte_valid);

  p_valid_in_last_phase_r7: assert property (@(posedge clk) disable iff (rst)
    byte_valid |-> (phase == 3'd7));

  p_byte_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !byte_valid |-> $stable(fetch_byte));

  p_idle_at_start_r3: assert property (@(posedge clk) disable iff (rst)
    (phase == 3'd0) |-> (ras_n && cas_n));
endmodule

bind nfs_fetch_seq nfs_fetch_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst(rst), .phase(phase), .ras_n(ras_n), .cas_n(cas_n),
  .byte_valid(byte_valid), .fetch_byte(fetch_byte)
);

// File: tb/tb_nfs_fetch_seq.sv
`timescale 1ns/1ps
module tb_nfs_fetch_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] start_addr = '0;
  logic        fetch_win = 1'b0;
  logic        row_gap = 1'b0;
  logic [3:0]  access_div = 4'd1;
  logic [15:0] screen_size = 16'h5000;
  logic [3:0]  dram_q;
  logic [8:0]  mem_addr;
  logic        ras_n, cas_n;
  logic [7:0]  fetch_byte;
  logic        byte_valid;

  int tests = 0;
  int fails = 0;
  int exp_addr = 0;
  int acc = 0;
  int div_v = 1;
  int ss_v = 0;
  logic [8:0] row_q = '0;

  nfs_fetch_seq dut (
    .clk(clk), .rst(rst), .start_addr(start_addr), .fetch_win(fetch_win),
    .row_gap(row_gap), .access_div(access_div), .screen_size(screen_size),
    .dram_q(dram_q), .mem_addr(mem_addr), .ras_n(ras_n), .cas_n(cas_n),
    .fetch_byte(fetch_byte), .byte_valid(byte_valid)
  );

  always #2 clk = ~clk;

  function automatic logic [7:0] pat(input logic [15:0] a);
    return a[7:0] ^ {a[14:8], a[15]} ^ 8'h3C;
  endfunction

  // DRAM model: row latched while ras_n is high, nibble chosen by column bit 0
  always @(posedge clk) if (ras_n) row_q <= mem_addr;
  logic [15:0] dram_byte_addr;
  logic [7:0]  dram_byte;
  assign dram_byte_addr = {row_q, mem_addr[7:1]};
  assign dram_byte      = pat(dram_byte_addr);
  assign dram_q = cas_n ? 4'h0 : (mem_addr[0] ? dram_byte[3:0] : dram_byte[7:4]);

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int wrapf(input int a);
    int n = a + 8;
    if (n >= 32'h8000) n = n - ss_v;
    return n;
  endfunction

  task automatic do_reset(input int st, input int dv, input int ss);
    @(negedge clk);
    rst = 1'b1; start_addr = st[15:0]; access_div = dv[3:0];
    screen_size = ss[15:0]; fetch_win = 1'b0; row_gap = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 ras_n", ras_n, 1);
    chk("R1 cas_n", cas_n, 1);
    chk("R1 byte_valid", byte_valid, 0);
    chk("R1 fetch_byte", fetch_byte, 0);
    chk("R1 mem_addr", mem_addr, 0);
    rst = 1'b0;
    exp_addr = st; acc = 0; div_v = dv; ss_v = ss;
  endtask

  task automatic period(input logic win, input logic gap);
    logic go;
    int a;
    int prev;
    logic [15:0] a16;
    fetch_win = win; row_gap = gap;
    go = (acc == 0) && win && !gap;
    a = exp_addr; a16 = a[15:0];
    prev = fetch_byte;
    for (int j = 1; j <= 8; j++) begin
      @(posedge clk); @(negedge clk);
      if (go) begin
        case (j)
          1: begin
            chk("R2 R4 R8 row address", mem_addr, a16[15:7]);
            chk("R4 ras_n before strobe", ras_n, 1);
          end
          2: begin
            chk("R4 ras_n low", ras_n, 0);
            chk("R5 even column", mem_addr, {1'b0, a16[6:0], 1'b0});
            chk("R5 cas_n high", cas_n, 1);
          end
          3: chk("R5 cas_n low", cas_n, 0);
          4: begin
            chk("R5 cas_n held", cas_n, 0);
            chk("R5 column held", mem_addr, {1'b0, a16[6:0], 1'b0});
          end
          5: begin
            chk("R6 cas_n released", cas_n, 1);
            chk("R6 odd column", mem_addr, {1'b0, a16[6:0], 1'b1});
            chk("R4 ras_n held", ras_n, 0);
          end
          6: chk("R6 cas_n low again", cas_n, 0);
          7: begin
            chk("R7 byte_valid", byte_valid, 1);
            chk("R5 R6 R7 byte", fetch_byte, pat(a16));
          end
          default: begin
            chk("R7 valid drop", byte_valid, 0);
            chk("R7 strobes released", {ras_n, cas_n}, 3);
          end
        endcase
      end else if (j == 2 || j == 7) begin
        chk((win && !gap) ? "R3 R9 skipped slot" : "R3 idle period",
            {ras_n, cas_n, byte_valid}, 3'b110);
        chk("R3 byte kept", fetch_byte, prev);
      end
    end
    if (go) exp_addr = wrapf(a);
    acc = (acc + 1 >= div_v) ? 0 : acc + 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // R1 R2: reset load and continuous fetching
    do_reset(32'h1000, 1, 32'h5000);
    for (int i = 0; i < 4; i++) period(1'b1, 1'b0);

    // R8: wrap across the top of screen memory, two sizes
    do_reset(32'h7FE0, 1, 32'h5000);
    for (int i = 0; i < 7; i++) period(1'b1, 1'b0);
    do_reset(32'h7FF0, 1, 32'h2800);
    for (int i = 0; i < 5; i++) period(1'b1, 1'b0);

    // R3: window and spacing-line gating
    do_reset(32'h3458, 1, 32'h5000);
    period(1'b0, 1'b0);
    period(1'b1, 1'b1);
    period(1'b1, 1'b0);
    period(1'b0, 1'b1);
    period(1'b1, 1'b0);

    // R9: divisor sweep including 0, with both screen sizes
    for (int dv = 0; dv <= 4; dv++) begin
      for (int s = 0; s < 2; s++) begin
        do_reset(32'h7FC8 - dv * 8, dv, (s == 0) ? 32'h5000 : 32'h2800);
        for (int i = 0; i < 12; i++) period(1'b1, (i % 5) == 3);
      end
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule